// File: doc/BRIEF.md
# Pipelined Four-Tap FIR Filter

This block is a single-rate finite impulse response filter with four fixed signed coefficients. It accepts one sample per clock and returns one filtered sample per clock. Each tap pairs a multiplier with an adder. A register sits after the multiplier and another after the adder, so the longest combinational path is a single multiply or a single add. Each pair maps onto one hard multiply-accumulate slice.

The partial sums move down a registered chain. The chain starts from a constant zero at the first tap and reaches the output at the last tap. The input sample line carries extra registers so that every tap meets the sample that the FIR equation needs at the moment its partial sum arrives. A valid flag travels beside the data with a fixed latency. Cycles without a valid input act as zero samples.

Top module: `fir_systolic4`

## Requirements
- R1: With x[n] the n-th sample captured after reset, the filtered value is y[n] = h0·x[n] + h1·x[n-1] + h2·x[n-2] + h3·x[n-3]. It is computed in signed two's complement with default coefficients h0 = 1234, h1 = -321, h2 = 4000, h3 = -32768.
- R2: Suppose a sample is captured on rising edge e. After edge e+5, out_valid equals the in_valid of edge e, and out_sample equals y for that sample.
- R3: out_sample is 34 bits wide. The value is exact for full-scale inputs, including -32768 against the -32768 coefficient, and it never exceeds (|h0|+|h1|+|h2|+|h3|)·32768 in magnitude.
- R4: On an edge where in_valid is low, a zero sample enters the filter whatever in_sample holds. After 10 or more consecutive such edges, out_sample is 0.
- R5: The reset is synchronous and active high. After any edge with rst high, out_valid is 0 and out_sample is 0. No sample captured before reset contributes to any later output.
- R6: If a valid input holds the same value x for 10 or more consecutive edges, out_sample equals (h0+h1+h2+h3)·x, which is -27855·x.
- R7: A single valid sample of 1 followed by zero samples yields h0, h1, h2 and h3, in that order, on four consecutive outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when in_sample carries a sample |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | High when out_sample carries a filtered sample |
| out_sample | output | 34 | Signed filtered sample |

## Verification
The hardest case to reach from the ports is a bubble in the middle of a stream. A cycle with in_valid low and a nonzero in_sample must enter the skewed delay line as zero, while its neighbours are already spread across taps at different pipeline depths. The stimulus places invalid cycles with nonzero data between valid samples, both in a short directed run and inside a long pseudo-random stream. Every output is compared against a convolution over the zero-filled history. A reset asserted in the middle of a stream, followed by a fresh burst, shows that no stale sample leaks through the skew line.

// File: rtl/fir_sys_pkg.sv
package fir_sys_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_COEF_W = 16;
    localparam int DEF_TAPS   = 4;

    // coefficient k occupies bits [16k +: 16]: h0=1234, h1=-321, h2=4000, h3=-32768
    localparam logic [63:0] DEF_COEFS = 64'h8000_0FA0_FEBF_04D2;

    // bits needed above the product width so the summed taps never wrap
    function automatic int guard_bits(input int taps);
        return (taps <= 1) ? 0 : $clog2(taps);
    endfunction

    // tap k reads the sample line at position 2k: k for the FIR delay, k for chain skew
    function automatic int skew_depth(input int taps);
        return 2 * taps - 1;
    endfunction

    // input register + product register + one register per adder
    function automatic int pipe_latency(input int taps);
        return taps + 2;
    endfunction

endpackage

// File: rtl/fir_sys_skew.sv
module fir_sys_skew #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic signed [DATA_W-1:0]     in_sample,
    output logic [DEPTH-1:0][DATA_W-1:0] line_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            // an empty slot travels as a zero sample
            line_q[0] <= in_valid ? in_sample : '0;
            for (int j = 1; j < DEPTH; j++) begin
                line_q[j] <= line_q[j-1];
            end
        end
    end

endmodule

// File: rtl/fir_sys_tap.sv
module fir_sys_tap #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34,
    parameter logic signed [COEF_W-1:0] COEF = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [ACC_W-1:0]  sum_in,
    output logic signed [ACC_W-1:0]  sum_out
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            sum_out <= '0;
        end else begin
            prod_q  <= PROD_W'(sample) * PROD_W'(COEF);
            sum_out <= sum_in + ACC_W'(prod_q);
        end
    end

endmodule

// File: rtl/fir_sys_vpipe.sv
module fir_sys_vpipe #(
    parameter int LAT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic out_valid
);

    logic [LAT-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LAT-2:0], in_valid};
        end
    end

    assign out_valid = stage_q[LAT-1];

endmodule

// File: rtl/fir_systolic4.sv
module fir_systolic4
    import fir_sys_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int TAPS   = DEF_TAPS,
    parameter logic [TAPS*COEF_W-1:0] COEFS = DEF_COEFS,
    localparam int ACC_W = DATA_W + COEF_W + guard_bits(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_sample
);

    localparam int DEPTH = skew_depth(TAPS);
    localparam int LAT   = pipe_latency(TAPS);

    logic [DEPTH-1:0][DATA_W-1:0] line_q;
    logic signed [ACC_W-1:0]      psum [TAPS];

    fir_sys_skew #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_skew (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .line_q    (line_q)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_head
            fir_sys_tap #(
                .DATA_W (DATA_W),
                .COEF_W (COEF_W),
                .ACC_W  (ACC_W),
                .COEF   (COEFS[k*COEF_W +: COEF_W])
            ) u_tap (
                .clk     (clk),
                .rst     (rst),
                .sample  (line_q[2*k]),
                .sum_in  ('0),
                .sum_out (psum[k])
            );
        end else begin : g_body
            fir_sys_tap #(
                .DATA_W (DATA_W),
                .COEF_W (COEF_W),
                .ACC_W  (ACC_W),
                .COEF   (COEFS[k*COEF_W +: COEF_W])
            ) u_tap (
                .clk     (clk),
                .rst     (rst),
                .sample  (line_q[2*k]),
                .sum_in  (psum[k-1]),
                .sum_out (psum[k])
            );
        end
    end

    fir_sys_vpipe #(.LAT(LAT)) u_vpipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    assign out_sample = psum[TAPS-1];

endmodule

// File: rtl/fir_systolic4_chk.sv
module fir_systolic4_chk
    import fir_sys_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int TAPS   = DEF_TAPS,
    parameter logic [TAPS*COEF_W-1:0] COEFS = DEF_COEFS,
    parameter int ACC_W  = DATA_W + COEF_W + guard_bits(TAPS)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_sample,
    input logic                     out_valid,
    input logic signed [ACC_W-1:0]  out_sample
);

    localparam int LAT = pipe_latency(TAPS);
    localparam int unsigned WIN = LAT + TAPS;

    function automatic longint coef_total(input bit use_abs);
        longint acc = 0;
        for (int k = 0; k < TAPS; k++) begin
            longint c = longint'($signed(COEFS[k*COEF_W +: COEF_W]));
            acc += (use_abs && c < 0) ? -c : c;
        end
        return acc;
    endfunction

    localparam longint SUM_H = coef_total(1'b0);
    localparam longint BOUND = coef_total(1'b1) * (longint'(1) <<< (DATA_W - 1));

    logic [LAT-1:0]           vsh_q;
    logic signed [DATA_W-1:0] last_x_q;
    logic                     last_v_q;
    int unsigned              run_dc_q;
    int unsigned              run_idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vsh_q      <= '0;
            last_x_q   <= '0;
            last_v_q   <= 1'b0;
            run_dc_q   <= 0;
            run_idle_q <= 0;
        end else begin
            vsh_q    <= {vsh_q[LAT-2:0], in_valid};
            last_x_q <= in_sample;
            last_v_q <= in_valid;
            if (in_valid && last_v_q && in_sample == last_x_q)
                run_dc_q <= (run_dc_q >= WIN) ? WIN : run_dc_q + 1;
            else
                run_dc_q <= in_valid ? 1 : 0;
            if (!in_valid)
                run_idle_q <= (run_idle_q >= WIN) ? WIN : run_idle_q + 1;
            else
                run_idle_q <= 0;
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsh_q[LAT-1]);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (longint'(out_sample) <= BOUND) && (longint'(out_sample) >= -BOUND));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (run_idle_q >= WIN) |-> (out_sample == '0));

    assert_reset_clear_R5: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    assert_dc_gain_R6: assert property (@(posedge clk) disable iff (rst)
        (run_dc_q >= WIN) |-> (longint'(out_sample) == SUM_H * longint'(last_x_q)));

endmodule

bind fir_systolic4 fir_systolic4_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .COEFS  (COEFS),
    .ACC_W  (ACC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/fir_systolic4_bench.sv
module fir_systolic4_bench;

    localparam int DELAY = 5;      // edges from capture to visible output
    localparam int HMAX  = 1024;
    localparam longint H [4] = '{1234, -321, 4000, -32768};

    typedef struct packed {
        logic              v;
        logic signed [15:0] x;
        logic [3:0]        req;
    } vec_t;

    localparam vec_t VECS [32] = '{
        // impulse (R7)
        '{1'b1, 16'sd1, 4'd7}, '{1'b1, 16'sd0, 4'd7}, '{1'b1, 16'sd0, 4'd7}, '{1'b1, 16'sd0, 4'd7},
        '{1'b1, 16'sd0, 4'd7}, '{1'b1, 16'sd0, 4'd7}, '{1'b1, 16'sd0, 4'd7}, '{1'b1, 16'sd0, 4'd7},
        // step (R6)
        '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6},
        '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6},
        '{1'b1, 16'sd1000, 4'd6}, '{1'b1, 16'sd1000, 4'd6},
        // bubbles carrying nonzero data (R4)
        '{1'b0, 16'sd12345, 4'd4}, '{1'b0, 16'sd12345, 4'd4}, '{1'b0, -16'sd77, 4'd4},
        '{1'b1, -16'sd500, 4'd4}, '{1'b0, -16'sd7, 4'd4}, '{1'b1, 16'sd250, 4'd4},
        // full scale (R3)
        '{1'b1, 16'sh8000, 4'd3}, '{1'b1, 16'sh8000, 4'd3}, '{1'b1, 16'sh8000, 4'd3}, '{1'b1, 16'sh8000, 4'd3},
        '{1'b1, 16'sh8000, 4'd3}, '{1'b1, 16'sh7FFF, 4'd3}, '{1'b1, 16'sh7FFF, 4'd3}, '{1'b1, 16'sh7FFF, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic              out_valid;
    logic signed [33:0] out_sample;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     cur      = 0;
    bit     done     = 1'b0;
    longint hx [HMAX];
    bit     hv [HMAX];
    int     htag [HMAX];

    always #2 clk = ~clk;

    fir_systolic4 u_fir_systolic4 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic longint x_at(input int i);
        return (i < 0) ? 0 : hx[i];
    endfunction

    function automatic longint v_at(input int i);
        return (i < 0) ? 0 : longint'(hv[i]);
    endfunction

    function automatic string tag_name(input int i);
        if (i < 0) return "R5";
        case (htag[i])
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic clear_history();
        for (int i = 0; i < HMAX; i++) begin
            hx[i] = 0; hv[i] = 1'b0; htag[i] = 0;
        end
        cur = 0;
    endtask

    // called at a falling edge: check the edge just passed, then drive the next sample
    task automatic step(input bit v, input logic signed [15:0] x, input int tag);
        int m = cur - 1;
        longint e = 0;
        for (int i = 0; i < 4; i++) e += H[i] * x_at(m - DELAY - i);
        check("R2", longint'(out_valid), v_at(m - DELAY));
        check(tag_name(m - DELAY), longint'(out_sample), e);
        in_valid  = v;
        in_sample = x;
        hx[cur]   = v ? longint'(x) : 0;
        hv[cur]   = v;
        htag[cur] = tag;
        cur++;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        clear_history();
        repeat (3) @(negedge clk);
        check("R5", longint'(out_valid), 0);
        check("R5", longint'(out_sample), 0);
        rst = 1'b0;

        for (int i = 0; i < 32; i++) step(VECS[i].v, VECS[i].x, int'(VECS[i].req));
        // drain with invalid cycles that carry junk (R4)
        for (int i = 0; i < 12; i++) step(1'b0, 16'sh5A5A, 4);

        // pseudo-random stream, about three quarters valid (R1)
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0] != 2'b00, $signed(lfsr ^ 16'h3C96), 1);
        end

        // reset in the middle of a stream (R5)
        in_valid  = 1'b1;
        in_sample = 16'sd5000;
        rst       = 1'b1;
        @(negedge clk);
        check("R5", longint'(out_valid), 0);
        check("R5", longint'(out_sample), 0);
        @(negedge clk);
        rst = 1'b0;
        clear_history();
        step(1'b1, 16'sd100, 5);
        step(1'b1, -16'sd200, 5);
        for (int i = 0; i < 10; i++) step(1'b0, 16'sd0, 5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired (R1)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule